// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block is a small programmable logic array of the kind found in simple fixed-architecture logic devices. A set of primary inputs is expanded into array lines. Each input produces two adjacent lines: its true value and its complement. A programmable AND plane combines those lines into product terms. Each output then ORs its own fixed, dedicated group of product terms. The OR results are registered and passed to a downstream macrocell. Signals that must feed back from that macrocell are brought in as ordinary primary inputs.

The connection pattern is held in a bank of fuse bits. A fuse at 0 is intact and connects its line into the product term. A fuse at 1 is blown and removes that line. The configuration port can:

- write one fuse, addressed by its absolute number;
- blow every fuse of one product term, which forces the term to constant 1;
- restore every fuse of one product term, which forces the term to constant 0, because both lines of an input are then connected.

The port can also read back any fuse. While configuration mode is active, the outputs are held low so that a partly programmed pattern never reaches the macrocell.

Top module: `pla_sop_array`

## Requirements
- R1: A synchronous reset clears every fuse to 0 (intact) and clears `sop_out` and `cfg_rdata`. With all fuses intact, every product term is 0, so every output stays 0 for any input pattern.
- R2: Input k drives array line 2k with its true value and line 2k+1 with its complement. Fuse number p*(2*NUM_IN)+l connects line l into product term p.
- R3: A product term is the AND of every line whose fuse is 0. A fuse at 1 drops its line from the AND.
- R4: Output o is the OR of product terms o*PT_PER_OUT to o*PT_PER_OUT+PT_PER_OUT-1, and of no other term.
- R5: Fuses change only in a cycle with `cfg_en`=1 and `cfg_we`=1. A write attempted with `cfg_en`=0 has no effect, and so does `cfg_op`=3 (reserved).
- R6: With `cfg_op`=0, a write sets fuse `cfg_addr` to `cfg_wdata` at the clock edge and leaves every other fuse unchanged.
- R7: With `cfg_op`=1, a write sets all fuses of product term `cfg_row` to 1, so that term evaluates to constant 1.
- R8: With `cfg_op`=2, a write clears all fuses of product term `cfg_row` to 0, so that term evaluates to constant 0.
- R9: `cfg_rdata` presents, one clock after `cfg_addr` is applied, the value fuse `cfg_addr` held before that edge.
- R10: `sop_out` is registered. It shows the array result for the inputs and fuses present at the previous clock edge. It is 0 on any edge at which `cfg_en` was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Configuration mode; holds outputs low and permits writes |
| cfg_we | input | 1 | Write strobe for the configuration port |
| cfg_op | input | 2 | 0 single fuse, 1 row all blown, 2 row all intact, 3 reserved |
| cfg_addr | input | $clog2(NUM_OUT*PT_PER_OUT*2*NUM_IN) | Absolute fuse number for single writes and readback |
| cfg_row | input | $clog2(NUM_OUT*PT_PER_OUT) | Product term number for row operations |
| cfg_wdata | input | 1 | Fuse value for single writes (1 = blown) |
| cfg_rdata | output | 1 | Readback of fuse `cfg_addr`, one cycle late |
| in_data | input | NUM_IN | Primary inputs (bit 0 is line pair 0/1) |
| sop_out | output | NUM_OUT | Registered OR results, one per output |

## Verification
The properties assume that reset is held for at least one edge before any configuration traffic. They also assume that the configuration controls are driven to known values on every edge. The row and address properties are only armed for in-range row and fuse numbers, so they presume the caller never relies on out-of-range writes. The stimulus changes every input on the falling clock edge, asserts reset first, and uses only valid fuse and row numbers except where a reserved operation code is deliberately applied.

// File: rtl/pla_pkg.sv
package pla_pkg;
  typedef enum logic [1:0] {
    CFG_BIT     = 2'd0,
    CFG_ROW_ON  = 2'd1,
    CFG_ROW_OFF = 2'd2,
    CFG_NOP     = 2'd3
  } cfg_op_e;
endpackage

// File: rtl/pla_fuse_store.sv
module pla_fuse_store #(
  parameter int LINES = 4,
  parameter int PTS   = 8,
  localparam int FUSES = LINES * PTS,
  localparam int FA_W  = $clog2(FUSES),
  localparam int PT_W  = $clog2(PTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_en,
  input  logic              cfg_we,
  input  pla_pkg::cfg_op_e  cfg_op,
  input  logic [FA_W-1:0]   cfg_addr,
  input  logic [PT_W-1:0]   cfg_row,
  input  logic              cfg_wdata,
  output logic              cfg_rdata,
  output logic [FUSES-1:0]  fuse_map
);
  import pla_pkg::*;

  logic [FUSES-1:0] fuse_q;
  logic             addr_ok;
  logic             row_ok;
  logic             wr_go;

  // Range guards: needed when FUSES or PTS is not a power of two.
  assign addr_ok = int'(cfg_addr) < FUSES;
  assign row_ok  = int'(cfg_row) < PTS;
  assign wr_go   = cfg_en && cfg_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      fuse_q    <= '0;
      cfg_rdata <= 1'b0;
    end else begin
      cfg_rdata <= addr_ok ? fuse_q[cfg_addr] : 1'b0;
      if (wr_go) begin
        unique case (cfg_op)
          CFG_BIT: begin
            if (addr_ok) fuse_q[cfg_addr] <= cfg_wdata;
          end
          CFG_ROW_ON: begin
            if (row_ok) fuse_q[int'(cfg_row)*LINES +: LINES] <= {LINES{1'b1}};
          end
          CFG_ROW_OFF: begin
            if (row_ok) fuse_q[int'(cfg_row)*LINES +: LINES] <= {LINES{1'b0}};
          end
          default: ;
        endcase
      end
    end
  end

  assign fuse_map = fuse_q;
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int LINES = 4,
  parameter int PTS   = 8,
  localparam int FUSES = LINES * PTS
) (
  input  logic [LINES-1:0] lines,
  input  logic [FUSES-1:0] fuse_map,
  output logic [PTS-1:0]   pterm
);
  // A blown fuse (1) forces its line to a neutral 1 inside the AND.
  for (genvar p = 0; p < PTS; p++) begin : g_pt
    assign pterm[p] = &(lines | fuse_map[p*LINES +: LINES]);
  end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int NUM_OUT    = 2,
  parameter int PT_PER_OUT = 4,
  localparam int PTS = NUM_OUT * PT_PER_OUT
) (
  input  logic [PTS-1:0]     pterm,
  output logic [NUM_OUT-1:0] or_out
);
  for (genvar o = 0; o < NUM_OUT; o++) begin : g_or
    assign or_out[o] = |pterm[o*PT_PER_OUT +: PT_PER_OUT];
  end
endmodule

// File: rtl/pla_sop_array.sv
module pla_sop_array #(
  parameter int NUM_IN     = 2,
  parameter int NUM_OUT    = 2,
  parameter int PT_PER_OUT = 4,
  localparam int LINES = 2 * NUM_IN,
  localparam int PTS   = NUM_OUT * PT_PER_OUT,
  localparam int FUSES = LINES * PTS,
  localparam int FA_W  = $clog2(FUSES),
  localparam int PT_W  = $clog2(PTS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_en,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_op,
  input  logic [FA_W-1:0]    cfg_addr,
  input  logic [PT_W-1:0]    cfg_row,
  input  logic               cfg_wdata,
  output logic               cfg_rdata,
  input  logic [NUM_IN-1:0]  in_data,
  output logic [NUM_OUT-1:0] sop_out
);
  import pla_pkg::*;

  logic [FUSES-1:0]   fuse_map;
  logic [LINES-1:0]   lines;
  logic [PTS-1:0]     pterm;
  logic [NUM_OUT-1:0] or_out;
  logic [NUM_OUT-1:0] sop_q;

  // True line on even index, complement on the following odd index.
  for (genvar k = 0; k < NUM_IN; k++) begin : g_lines
    assign lines[2*k]   = in_data[k];
    assign lines[2*k+1] = ~in_data[k];
  end

  pla_fuse_store #(.LINES(LINES), .PTS(PTS)) u_store (
    .clk       (clk),
    .rst       (rst),
    .cfg_en    (cfg_en),
    .cfg_we    (cfg_we),
    .cfg_op    (cfg_op_e'(cfg_op)),
    .cfg_addr  (cfg_addr),
    .cfg_row   (cfg_row),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .fuse_map  (fuse_map)
  );

  pla_and_plane #(.LINES(LINES), .PTS(PTS)) u_and (
    .lines    (lines),
    .fuse_map (fuse_map),
    .pterm    (pterm)
  );

  pla_or_plane #(.NUM_OUT(NUM_OUT), .PT_PER_OUT(PT_PER_OUT)) u_or (
    .pterm  (pterm),
    .or_out (or_out)
  );

  always_ff @(posedge clk) begin
    if (rst || cfg_en) sop_q <= '0;
    else               sop_q <= or_out;
  end

  assign sop_out = sop_q;
endmodule

// File: rtl/pla_sop_array_chk.sv
module pla_sop_array_chk #(
  parameter int NUM_IN     = 2,
  parameter int NUM_OUT    = 2,
  parameter int PT_PER_OUT = 4,
  localparam int LINES = 2 * NUM_IN,
  localparam int PTS   = NUM_OUT * PT_PER_OUT,
  localparam int FUSES = LINES * PTS,
  localparam int FA_W  = $clog2(FUSES),
  localparam int PT_W  = $clog2(PTS)
) (
  input logic               clk,
  input logic               rst,
  input logic               cfg_en,
  input logic               cfg_we,
  input logic [1:0]         cfg_op,
  input logic [FA_W-1:0]    cfg_addr,
  input logic [PT_W-1:0]    cfg_row,
  input logic               cfg_wdata,
  input logic               cfg_rdata,
  input logic [NUM_OUT-1:0] sop_out,
  input logic [FUSES-1:0]   fuse_map
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (sop_out == '0) && (cfg_rdata == 1'b0) && (fuse_map == '0));

  p_no_write_r5: assert property (@(posedge clk) disable iff (rst)
    !(cfg_en && cfg_we && cfg_op != 2'd3) |=> $stable(fuse_map));

  p_bit_write_r6: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && cfg_we && cfg_op == 2'd0 && int'(cfg_addr) < FUSES)
    |=> fuse_map[$past(cfg_addr)] == $past(cfg_wdata));

  p_bit_single_r6: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && cfg_we && cfg_op == 2'd0)
    |=> $countones(fuse_map ^ $past(fuse_map)) <= 1);

  p_row_on_r7: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && cfg_we && cfg_op == 2'd1 && int'(cfg_row) < PTS)
    |=> fuse_map[int'($past(cfg_row))*LINES +: LINES] == {LINES{1'b1}});

  p_row_off_r8: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && cfg_we && cfg_op == 2'd2 && int'(cfg_row) < PTS)
    |=> fuse_map[int'($past(cfg_row))*LINES +: LINES] == {LINES{1'b0}});

  p_readback_r9: assert property (@(posedge clk) disable iff (rst)
    (int'(cfg_addr) < FUSES) |=> cfg_rdata == $past(fuse_map[cfg_addr]));

  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> sop_out == '0);
endmodule

bind pla_sop_array pla_sop_array_chk #(
  .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .PT_PER_OUT(PT_PER_OUT)
) chk_i (.*);

// File: tb/pla_sop_array_tb_top.sv
module pla_sop_array_tb_top;
  localparam int NUM_IN = 2;
  localparam int NUM_OUT = 2;
  localparam int PT_PER_OUT = 4;
  localparam int FUSES = 2 * NUM_IN * NUM_OUT * PT_PER_OUT;
  localparam int FA_W = $clog2(FUSES);
  localparam int PT_W = $clog2(NUM_OUT * PT_PER_OUT);

  // Fuses blown to build X = A*B + /A*B (terms 0,1) and Y = A*/B (term 4).
  // Lines: 0=A 1=/A 2=B 3=/B; fuse = term*4 + line.
  localparam int NWR = 6;
  localparam int BLOW[NWR] = '{1, 3, 4, 7, 17, 18};
  // Vectors {B, A, expY, expX}.
  localparam logic [3:0] VEC[4] = '{4'b0000, 4'b0110, 4'b1001, 4'b1101};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_en = 1'b0, cfg_we = 1'b0, cfg_wdata = 1'b0;
  logic [1:0] cfg_op = 2'd0;
  logic [FA_W-1:0] cfg_addr = '0;
  logic [PT_W-1:0] cfg_row = '0;
  logic cfg_rdata;
  logic [NUM_IN-1:0] in_data = '0;
  logic [NUM_OUT-1:0] sop_out;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  pla_sop_array #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .PT_PER_OUT(PT_PER_OUT)) dut_i (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_we(cfg_we), .cfg_op(cfg_op),
    .cfg_addr(cfg_addr), .cfg_row(cfg_row), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .in_data(in_data), .sop_out(sop_out));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] op, input int addr, input int row, input logic val,
                           input logic en);
    @(negedge clk);
    cfg_en = en; cfg_we = 1'b1; cfg_op = op;
    cfg_addr = FA_W'(addr); cfg_row = PT_W'(row); cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0; cfg_op = 2'd0;
  endtask

  task automatic read_fuse(input int addr, output logic val);
    @(negedge clk);
    cfg_addr = FA_W'(addr);
    @(negedge clk);
    val = cfg_rdata;
  endtask

  task automatic eval(input logic [1:0] ins, output logic [1:0] res);
    @(negedge clk);
    cfg_en = 1'b0; in_data = ins;
    @(negedge clk);
    res = sop_out;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [1:0] r;
    logic b;
    repeat (3) @(negedge clk);
    // R1: reset state.
    check("R1 sop_out after reset", 8'(sop_out), 8'h0);
    check("R1 rdata after reset", 8'(cfg_rdata), 8'h0);
    rst = 1'b0;
    eval(2'b11, r);
    check("R1 all intact gives 0", 8'(r), 8'h0);

    // Program the pattern in configuration mode.
    for (int i = 0; i < NWR; i++) cfg_write(2'd0, BLOW[i], 0, 1'b1, 1'b1);
    // R10: held low while configuring, even for an input that gives X=1.
    in_data = 2'b10;
    @(negedge clk);
    check("R10 held low in config", 8'(sop_out), 8'h0);

    // R2 R3 R4: table walk.
    for (int v = 0; v < 4; v++) begin
      eval(VEC[v][3:2], r);
      check("R2 R3 R4 vector", 8'(r), 8'(VEC[v][1:0]));
    end

    // R10: registered, output lags an input change until the next edge.
    eval(2'b10, r);
    @(negedge clk);
    in_data = 2'b01;
    #1;
    check("R10 before edge", 8'(sop_out), 8'h1);
    @(negedge clk);
    check("R10 after edge", 8'(sop_out), 8'h2);

    // R9: readback.
    read_fuse(1, b);  check("R9 readback blown", 8'(b), 8'h1);
    read_fuse(2, b);  check("R9 readback intact", 8'(b), 8'h0);
    read_fuse(18, b); check("R9 readback Y term", 8'(b), 8'h1);

    // R5: write with cfg_en low is ignored.
    cfg_write(2'd0, 2, 0, 1'b1, 1'b0);
    read_fuse(2, b);  check("R5 write without cfg_en ignored", 8'(b), 8'h0);
    // R6: a single write changes only its own fuse.
    cfg_write(2'd0, 0, 0, 1'b1, 1'b1);
    read_fuse(0, b);  check("R6 single write", 8'(b), 8'h1);
    read_fuse(1, b);  check("R6 neighbour kept", 8'(b), 8'h1);
    cfg_write(2'd0, 0, 0, 1'b0, 1'b1);

    // R7: row 6 (in Y group) all blown, so Y=1 everywhere.
    cfg_write(2'd1, 0, 6, 1'b0, 1'b1);
    eval(2'b00, r);
    check("R7 row on forces Y", 8'(r), 8'h2);
    // R8: restore row 6.
    cfg_write(2'd2, 0, 6, 1'b0, 1'b1);
    eval(2'b00, r);
    check("R8 row off restores Y", 8'(r), 8'h0);
    // R8: clear term 0 (A*B), leaving X = /A*B.
    cfg_write(2'd2, 0, 0, 1'b0, 1'b1);
    eval(2'b11, r);
    check("R8 cleared term 0", 8'(r), 8'h0);
    eval(2'b10, r);
    check("R4 other term still drives X", 8'(r), 8'h1);
    // R5: reserved op 3 on term 1 has no effect.
    cfg_write(2'd3, 0, 1, 1'b0, 1'b1);
    eval(2'b10, r);
    check("R5 reserved op ignored", 8'(r), 8'h1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule